// File: doc/BRIEF.md
# Indirect Register Access Bridge for a Shared Management Bus

This block sits on the device side of a management bus and gives one bus address access to many internal register sets. A strap input picks the addressing scheme. When the strap is zero the bridge runs in single-chip mode: it claims every bus address and passes each access straight to the internal register bus. The bus address becomes the internal device address and the bus register offset becomes the internal register address.

When the strap is non-zero the bridge runs in multichip mode and claims only the strapped address. That address holds two registers: a command register at offset 0 and a data register at offset 1. Software puts write data in the data register. It then writes a command word that names an internal device, a register and an operation. A busy flag in bit 15 of the command register stays set while the internal access runs, and the result of a read is left in the data register.

The bridge sees the bus as decoded read and write strobes, one cycle each. It reaches the internal register bus through a request/acknowledge handshake. Read data comes back on the bus with a one-cycle valid pulse.

Top module: `smi_mc_bridge`

## Requirements
- R1: After reset no internal request is pending, and in multichip mode both the command register and the data register read as 0.
- R2: In multichip mode the bridge claims an access (bus_hit high) only when bus_addr equals strap_addr. An unclaimed write changes nothing, and an unclaimed read produces no bus_rvalid pulse.
- R3: In multichip mode a read at offset 1 returns the last value written there, and a read at offset 0 returns the stored command bits 14:0. Any other offset reads as 0. A register read raises bus_rvalid in the cycle after the read strobe.
- R4: A multichip command with bit 15 set, bit 12 set and bits 11:10 equal to 01 performs one internal write. The write goes to device bits 9:5 and register bits 4:0, and it carries the value held in the data register when the command was written.
- R5: A multichip command with bit 15 set, bit 12 set and bits 11:10 equal to 10 performs one internal read of device bits 9:5 and register bits 4:0. The 16-bit result is left in the data register.
- R6: int_req, int_dev, int_reg, int_we and int_wdata stay steady until int_ack. int_req, which is the busy flag, is low in the cycle after the acknowledge.
- R7: A command written while busy is ignored. No second internal access takes place, and the stored command does not change.
- R8: A command whose opcode is 00 or 11, or whose bit 12 is clear, or whose bit 15 is clear, is stored but starts no internal access. Busy reads back as clear.
- R9: In single-chip mode every bus address is claimed. A bus write becomes an internal write, and a bus read becomes an internal read, to device bus_addr and register bus_reg. The read result comes back on bus_rdata with a bus_rvalid pulse in the cycle after int_ack. This applies at offset 0 as well.
- R10: In multichip mode a write to the data register while busy is ignored.
- R11: While busy, a read of the command register returns the stored command with bit 15 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_addr | input | 5 | Strapped bus address; zero selects single-chip mode |
| bus_addr | input | 5 | Bus address of the current access |
| bus_reg | input | 5 | Register offset of the current access |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 16 | Bus write data |
| bus_hit | output | 1 | The bridge claims the current address |
| bus_rdata | output | 16 | Bus read data |
| bus_rvalid | output | 1 | bus_rdata is valid this cycle |
| int_req | output | 1 | Internal access request; also the busy flag |
| int_we | output | 1 | Internal access is a write |
| int_dev | output | 5 | Internal device address |
| int_reg | output | 5 | Internal register address |
| int_wdata | output | 16 | Internal write data |
| int_ack | input | 1 | Internal access complete |
| int_rdata | input | 16 | Internal read data, valid with int_ack |

## Verification
The hardest case to reach is a bus write that lands while an internal access is still open, since busy normally lasts only a few cycles. The bench's model of the internal register bus holds its acknowledge back for a chosen number of cycles. With a long delay, a second command, a data write and a command-register poll can all be placed inside the busy window. The results are then read back once the access ends. The same model counts internal accesses, so a command that must start nothing is seen at the ports as an unchanged count.

// File: rtl/smi_mc_bridge.sv
module smi_mc_bridge #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] strap_addr,
  input  logic [AW-1:0] bus_addr,
  input  logic [AW-1:0] bus_reg,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_hit,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          int_req,
  output logic          int_we,
  output logic [AW-1:0] int_dev,
  output logic [AW-1:0] int_reg,
  output logic [DW-1:0] int_wdata,
  input  logic          int_ack,
  input  logic [DW-1:0] int_rdata
);

  localparam int BUSY_B = DW - 1;
  localparam int C22_B  = 12;
  localparam int OP_LO  = 10;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [AW-1:0] OFS_CMD = '0;
  localparam logic [AW-1:0] OFS_DAT = AW'(1);

  logic [BUSY_B-1:0] cmd_q;
  logic [DW-1:0]     data_q;
  logic              busy_q, direct_q;

  wire multi  = strap_addr != '0;
  assign bus_hit = !multi || (bus_addr == strap_addr);

  wire acc_wr = bus_wr && bus_hit;
  wire acc_rd = bus_rd && bus_hit;
  wire [1:0] op = bus_wdata[OP_LO+1:OP_LO];
  wire cmd_ok = bus_wdata[BUSY_B] && bus_wdata[C22_B] && (op == OP_RD || op == OP_WR);

  wire reg_wr    = multi && acc_wr && !busy_q;
  wire start_ind = reg_wr && bus_reg == OFS_CMD && cmd_ok;
  wire start_dir = !multi && (acc_wr || acc_rd) && !busy_q;
  wire done      = busy_q && int_ack;

  assign int_req = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      data_q     <= '0;
      busy_q     <= 1'b0;
      direct_q   <= 1'b0;
      int_we     <= 1'b0;
      int_dev    <= '0;
      int_reg    <= '0;
      int_wdata  <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= 1'b0;
      if (reg_wr && bus_reg == OFS_CMD) cmd_q  <= bus_wdata[BUSY_B-1:0];
      if (reg_wr && bus_reg == OFS_DAT) data_q <= bus_wdata;
      if (start_ind) begin
        busy_q    <= 1'b1;
        direct_q  <= 1'b0;
        int_we    <= op == OP_WR;
        int_dev   <= bus_wdata[2*AW-1:AW];
        int_reg   <= bus_wdata[AW-1:0];
        int_wdata <= data_q;
      end
      if (start_dir) begin
        busy_q    <= 1'b1;
        direct_q  <= 1'b1;
        int_we    <= bus_wr;
        int_dev   <= bus_addr;
        int_reg   <= bus_reg;
        int_wdata <= bus_wdata;
      end
      if (done) begin
        busy_q <= 1'b0;
        if (!int_we && direct_q) begin
          bus_rdata  <= int_rdata;
          bus_rvalid <= 1'b1;
        end
        if (!int_we && !direct_q) data_q <= int_rdata;
      end
      if (multi && acc_rd) begin
        bus_rvalid <= 1'b1;
        case (bus_reg)
          OFS_CMD: bus_rdata <= {busy_q, cmd_q};
          OFS_DAT: bus_rdata <= data_q;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack) |=> (int_req && $stable({int_dev, int_reg, int_we, int_wdata}))); // R6
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack) |=> !int_req); // R6
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req) |-> $past((bus_wr || bus_rd) && bus_hit)); // R2
  AST_MC_CMD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && $rose(int_req)) |-> $past(bus_wr && bus_reg == OFS_CMD)); // R4
  AST_DIRECT_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!multi && bus_rvalid) |-> $past(int_req && int_ack && !int_we)); // R9

endmodule

// File: tb/sim_smi_mc_bridge.sv
module sim_smi_mc_bridge;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] strap_addr = 5'd5, bus_addr = '0, bus_reg = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic bus_hit, bus_rvalid, int_req, int_we;
  logic [15:0] bus_rdata, int_wdata;
  logic [4:0] int_dev, int_reg;
  logic int_ack = 1'b0;
  logic [15:0] int_rdata = '0;

  int errors = 0, checks = 0;
  int lat = 2, wcnt = 0, acc_count = 0;
  logic [15:0] mem [0:1023];

  always #(PERIOD/2) clk = ~clk;

  smi_mc_bridge u0 (.clk, .rst_n, .strap_addr, .bus_addr, .bus_reg, .bus_wr, .bus_rd,
    .bus_wdata, .bus_hit, .bus_rdata, .bus_rvalid, .int_req, .int_we, .int_dev,
    .int_reg, .int_wdata, .int_ack, .int_rdata);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 37) ^ 16'hA5A5;
  end

  always @(negedge clk) begin
    if (int_ack) begin
      int_ack = 1'b0;
      chk("R6 busy low after ack", {31'd0, int_req}, 32'd0);
    end else if (int_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        int_ack = 1'b1;
        acc_count++;
        if (int_we) mem[{int_dev, int_reg}] = int_wdata;
        else int_rdata = mem[{int_dev, int_reg}];
      end else wcnt++;
    end
  end

  task automatic do_reset(input logic [4:0] s);
    rst_n = 1'b0;
    strap_addr = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_reg = r; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [4:0] a, input logic [4:0] r, output logic [15:0] d,
                       output logic got);
    @(negedge clk);
    bus_addr = a; bus_reg = r; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    got = 1'b0; d = '0;
    for (int i = 0; i < 40; i++) begin
      if (bus_rvalid) begin got = 1'b1; d = bus_rdata; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 100; i++) begin
      if (!int_req && !int_ack) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [15:0] d; logic g;
    do_reset(5'd5);
    chk("R1 req after reset", {31'd0, int_req}, 32'd0);
    bread(5'd5, 5'd0, d, g);
    chk("R1 cmd after reset", {15'd0, g, d}, {15'd0, 1'b1, 16'h0000});
    bread(5'd5, 5'd1, d, g);
    chk("R1 data after reset", {15'd0, g, d}, {15'd0, 1'b1, 16'h0000});
  endtask

  task automatic t_regs;
    logic [15:0] d; logic g; int c0;
    c0 = acc_count;
    bwrite(5'd5, 5'd1, 16'h1234);
    bread(5'd5, 5'd1, d, g);
    chk("R3 data readback", {15'd0, g, d}, {15'd0, 1'b1, 16'h1234});
    bread(5'd5, 5'd2, d, g);
    chk("R3 other offset", {15'd0, g, d}, {15'd0, 1'b1, 16'h0000});
    bwrite(5'd5, 5'd0, 16'h4321);
    bread(5'd5, 5'd0, d, g);
    chk("R3 cmd readback", {15'd0, g, d}, {15'd0, 1'b1, 16'h4321});
    chk("R8 bit15 clear no access", acc_count, c0);
  endtask

  task automatic t_filter;
    logic [15:0] d; logic g;
    @(negedge clk);
    bus_addr = 5'd6;
    #1 chk("R2 hit other addr", {31'd0, bus_hit}, 32'd0);
    bus_addr = 5'd5;
    #1 chk("R2 hit strap addr", {31'd0, bus_hit}, 32'd1);
    bwrite(5'd6, 5'd1, 16'hDEAD);
    bread(5'd5, 5'd1, d, g);
    chk("R2 foreign write ignored", {15'd0, g, d}, {15'd0, 1'b1, 16'h1234});
    bread(5'd6, 5'd1, d, g);
    chk("R2 foreign read silent", {31'd0, g}, 32'd0);
  endtask

  task automatic t_iwrite;
    int c0;
    lat = 3; c0 = acc_count;
    bwrite(5'd5, 5'd1, 16'hBEEF);
    bwrite(5'd5, 5'd0, 16'h9400 | (16'd9 << 5) | 16'd17);
    wait_idle();
    chk("R4 internal write", {16'd0, mem[{5'd9, 5'd17}]}, 32'h0000BEEF);
    chk("R4 one access", acc_count, c0 + 1);
  endtask

  task automatic t_iread;
    logic [15:0] d; logic g; logic [15:0] e;
    e = mem[{5'd20, 5'd4}];
    bwrite(5'd5, 5'd0, 16'h9800 | (16'd20 << 5) | 16'd4);
    wait_idle();
    bread(5'd5, 5'd1, d, g);
    chk("R5 read result", {15'd0, g, d}, {15'd0, 1'b1, e});
  endtask

  task automatic t_busy;
    logic [15:0] d; logic g;
    lat = 10;
    bwrite(5'd5, 5'd0, 16'h9800 | (16'd3 << 5) | 16'd2);
    bread(5'd5, 5'd0, d, g);
    chk("R11 cmd while busy", {15'd0, g, d}, {15'd0, 1'b1, 16'h9800 | (16'd3 << 5) | 16'd2});
    chk("R6 busy during access", {31'd0, int_req}, 32'd1);
    wait_idle();
    bread(5'd5, 5'd0, d, g);
    chk("R6 busy clear after", {16'd0, d}, {16'd0, 16'h1800 | (16'd3 << 5) | 16'd2});
  endtask

  task automatic t_ignore;
    logic [15:0] d; logic g; int c0;
    lat = 10;
    bwrite(5'd5, 5'd1, 16'h1111);
    c0 = acc_count;
    bwrite(5'd5, 5'd0, 16'h9400 | (16'd1 << 5) | 16'd1);
    bwrite(5'd5, 5'd0, 16'h9800 | (16'd2 << 5) | 16'd2);
    bwrite(5'd5, 5'd1, 16'h2222);
    wait_idle();
    chk("R7 single access", acc_count, c0 + 1);
    chk("R7 write data kept", {16'd0, mem[{5'd1, 5'd1}]}, 32'h00001111);
    bread(5'd5, 5'd0, d, g);
    chk("R7 cmd unchanged", {16'd0, d}, {16'd0, 16'h1400 | (16'd1 << 5) | 16'd1});
    bread(5'd5, 5'd1, d, g);
    chk("R10 data write ignored", {16'd0, d}, 32'h00001111);
  endtask

  task automatic t_illegal;
    logic [15:0] d; logic g; int c0;
    lat = 2; c0 = acc_count;
    bwrite(5'd5, 5'd0, 16'h9C00 | (16'd4 << 5) | 16'd4);
    bread(5'd5, 5'd0, d, g);
    chk("R8 opcode 11 busy clear", {16'd0, d}, {16'd0, 16'h1C00 | (16'd4 << 5) | 16'd4});
    bwrite(5'd5, 5'd0, 16'h9000);
    bwrite(5'd5, 5'd0, 16'h8800 | 16'd7);
    repeat (4) @(negedge clk);
    chk("R8 no access", acc_count, c0);
    chk("R8 req idle", {31'd0, int_req}, 32'd0);
  endtask

  task automatic t_single;
    logic [15:0] d; logic g; logic [15:0] e;
    do_reset(5'd0);
    lat = 4;
    @(negedge clk);
    bus_addr = 5'd31;
    #1 chk("R9 hit any addr", {31'd0, bus_hit}, 32'd1);
    bwrite(5'd7, 5'd3, 16'h5A5A);
    wait_idle();
    chk("R9 direct write", {16'd0, mem[{5'd7, 5'd3}]}, 32'h00005A5A);
    bwrite(5'd0, 5'd0, 16'h0F0F);
    wait_idle();
    chk("R9 offset 0 direct", {16'd0, mem[{5'd0, 5'd0}]}, 32'h00000F0F);
    e = mem[{5'd12, 5'd30}];
    bread(5'd12, 5'd30, d, g);
    chk("R9 direct read", {15'd0, g, d}, {15'd0, 1'b1, e});
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_filter();
    t_iwrite();
    t_iread();
    t_busy();
    t_ignore();
    t_illegal();
    t_single();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule